// File: doc/BRIEF.md
# Submodule Interrupt Vector Arbiter

This block stands between one timer submodule's interrupt source and the processor's interrupt acknowledge path. It takes the submodule's pending flag, a 3-bit request level and a 4-bit arbitration number, and compares the level against the processor's current priority mask. From that it decides, every cycle, whether to drive its contend line. The arbitration number is built from two places: a 3-bit field shared by the whole timer, and a single bit kept in the submodule's own register. The single bit is the most significant bit.

When the processor starts an acknowledge cycle, the block compares its own arbitration number with the highest number the competing sources present. If its number is strictly the largest, it returns an 8-bit vector for one cycle. The vector's top two bits are a shared vector base. Its low six bits are the submodule's number. The acknowledge cycle is reduced to a strobe in and a one-cycle vector-valid pulse out. The pending flag stays with the source until software clears it.

Top module: `irq_vec_arbiter`

## Requirements
- R1: With a request level of 0 the contend output stays low, whatever the mask and the pending flag.
- R2: For levels 1 to 6 with the pending flag set, contend is high exactly when the level is strictly greater than the mask. It follows the inputs in the same cycle.
- R3: A pending level-7 request contends for every mask value, including a mask of 7.
- R4: Without the pending flag, contend is low for every level and mask.
- R5: The local arbitration number is {arbTop, arbLow}, so arbTop is bit 3 and arbLow supplies bits 2:0.
- R6: A rising edge on ackStrobe is a win when contend is high and the local arbitration number is strictly greater than rivalMax. A tie or a smaller number loses. On a win, vecValid is high in the cycle after the clock edge that sees the rise. On a loss, or with contend low, vecValid stays low.
- R7: While vecValid is high, vecOut[7:6] equals vecBase and vecOut[5:0] equals subNum, as both were at the winning edge. Submodule 12 gives vecOut[5:0] = 6'b001100.
- R8: vecValid is high for one cycle per win even when ackStrobe is held high. vecOut is zero whenever vecValid is low.
- R9: While rstN is low, vecValid and vecOut are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqPending | input | 1 | Source flag raised by the submodule |
| irqLevel | input | 3 | Requested interrupt level |
| cpuMask | input | 3 | Processor's current priority mask |
| arbLow | input | 3 | Shared arbitration field (bits 2:0) |
| arbTop | input | 1 | Submodule's own arbitration bit (bit 3) |
| vecBase | input | 2 | Shared vector base |
| subNum | input | 6 | Submodule number |
| ackStrobe | input | 1 | Acknowledge cycle strobe; a rise starts arbitration |
| rivalMax | input | 4 | Highest arbitration number among competitors |
| contend | output | 1 | Request line towards the processor |
| vecValid | output | 1 | One-cycle pulse when the vector is returned |
| vecOut | output | 8 | Returned vector, zero when not valid |

## Verification
The contend decision is combinational, so a wrong level or mask comparison shows on the contend pin in the same cycle. The level sweep covers every combination of level, mask and pending flag. A bad edge detector or arbitration compare shows one cycle after the acknowledge rise, in one of three ways: a missing pulse, an extra pulse, or a pulse stretched over several cycles. A wrong vector assembly shows in the same cycle as vecValid, as misplaced base or number bits. The arbitration sweep covers every local number against every rival number, including all sixteen ties.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  typedef struct packed {
    logic loadVec;
    logic dropVec;
  } arbStrobes_t;
endpackage

// File: rtl/irq_vec_datapath.sv
module irq_vec_datapath
  import irq_vec_pkg::*;
#(
  parameter int LEVEL_W = 3,
  parameter int ARB_LO_W = 3,
  parameter int BASE_W = 2,
  parameter int SUB_W = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       irqPending,
  input  logic [LEVEL_W-1:0]         irqLevel,
  input  logic [LEVEL_W-1:0]         cpuMask,
  input  logic [ARB_LO_W-1:0]        arbLow,
  input  logic                       arbTop,
  input  logic [BASE_W-1:0]          vecBase,
  input  logic [SUB_W-1:0]           subNum,
  input  logic [ARB_LO_W:0]          rivalMax,
  input  arbStrobes_t                strobes,
  output logic                       contend,
  output logic                       winNow,
  output logic [BASE_W+SUB_W-1:0]    vecOut
);
  localparam int ARB_W = ARB_LO_W + 1;
  localparam int VEC_W = BASE_W + SUB_W;
  localparam logic [LEVEL_W-1:0] TOP_LEVEL = '1;

  logic [ARB_W-1:0] localArb;
  logic             levelNonZero;
  logic             aboveMask;
  logic [VEC_W-1:0] vecQ;

  always_comb begin
    localArb     = {arbTop, arbLow};
    levelNonZero = |irqLevel;
    aboveMask    = (irqLevel == TOP_LEVEL) || (irqLevel > cpuMask);
    contend      = irqPending && levelNonZero && aboveMask;
    winNow       = contend && (localArb > rivalMax);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecQ <= '0;
    end else if (strobes.loadVec) begin
      vecQ <= {vecBase, subNum};
    end else if (strobes.dropVec) begin
      vecQ <= '0;
    end
  end

  assign vecOut = vecQ;

  // R1: a zero level never reaches the contend line
  p_zero_level_r1: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel == '0) |-> !contend);

  // R3: the top level ignores the mask
  p_top_level_r3: assert property (@(posedge clk) disable iff (!rstN)
    (irqPending && irqLevel == TOP_LEVEL) |-> contend);

  // R4: no pending flag, no contention
  p_no_pending_r4: assert property (@(posedge clk) disable iff (!rstN)
    !irqPending |-> !contend);
endmodule

// File: rtl/irq_vec_control.sv
module irq_vec_control
  import irq_vec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ackStrobe,
  input  logic        winNow,
  output arbStrobes_t strobes,
  output logic        vecValid
);
  logic ackPrev;
  logic ackRise;
  logic validQ;

  always_comb begin
    ackRise         = ackStrobe && !ackPrev;
    strobes.loadVec = ackRise && winNow;
    strobes.dropVec = validQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackPrev <= 1'b0;
      validQ  <= 1'b0;
    end else begin
      ackPrev <= ackStrobe;
      validQ  <= strobes.loadVec;
    end
  end

  assign vecValid = validQ;

  // R8: the valid pulse never lasts two cycles
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |=> !vecValid);

  // R6: a held strobe does not start a second arbitration
  p_no_rearm_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && $past(ackStrobe)) |=> !vecValid);
endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter
  import irq_vec_pkg::*;
#(
  parameter int LEVEL_W = 3,
  parameter int ARB_LO_W = 3,
  parameter int BASE_W = 2,
  parameter int SUB_W = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    irqPending,
  input  logic [LEVEL_W-1:0]      irqLevel,
  input  logic [LEVEL_W-1:0]      cpuMask,
  input  logic [ARB_LO_W-1:0]     arbLow,
  input  logic                    arbTop,
  input  logic [BASE_W-1:0]       vecBase,
  input  logic [SUB_W-1:0]        subNum,
  input  logic                    ackStrobe,
  input  logic [ARB_LO_W:0]       rivalMax,
  output logic                    contend,
  output logic                    vecValid,
  output logic [BASE_W+SUB_W-1:0] vecOut
);
  arbStrobes_t strobes;
  logic        winNow;

  irq_vec_datapath #(
    .LEVEL_W(LEVEL_W), .ARB_LO_W(ARB_LO_W), .BASE_W(BASE_W), .SUB_W(SUB_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .irqPending(irqPending), .irqLevel(irqLevel),
    .cpuMask(cpuMask), .arbLow(arbLow), .arbTop(arbTop), .vecBase(vecBase),
    .subNum(subNum), .rivalMax(rivalMax), .strobes(strobes),
    .contend(contend), .winNow(winNow), .vecOut(vecOut)
  );

  irq_vec_control i_control (
    .clk(clk), .rstN(rstN), .ackStrobe(ackStrobe), .winNow(winNow),
    .strobes(strobes), .vecValid(vecValid)
  );

  // R6: a tie or a smaller local number never yields a vector
  p_tie_loses_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && !$past(ackStrobe) && ({arbTop, arbLow} <= rivalMax)) |=> !vecValid);

  // R7: the low vector bits carry the submodule number seen at the win
  p_vec_number_r7: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (vecOut[SUB_W-1:0] == $past(subNum)));

  // R8: no vector leaks out without the valid pulse
  p_vec_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !vecValid |-> (vecOut == '0));
endmodule

// File: tb/test_irq_vec_arbiter.sv
module test_irq_vec_arbiter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       irqPending = 1'b0;
  logic [2:0] irqLevel = '0;
  logic [2:0] cpuMask = '0;
  logic [2:0] arbLow = '0;
  logic       arbTop = 1'b0;
  logic [1:0] vecBase = '0;
  logic [5:0] subNum = '0;
  logic       ackStrobe = 1'b0;
  logic [3:0] rivalMax = '0;
  logic       contend;
  logic       vecValid;
  logic [7:0] vecOut;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vec_arbiter i_irq_vec_arbiter (
    .clk(clk), .rstN(rstN), .irqPending(irqPending), .irqLevel(irqLevel),
    .cpuMask(cpuMask), .arbLow(arbLow), .arbTop(arbTop), .vecBase(vecBase),
    .subNum(subNum), .ackStrobe(ackStrobe), .rivalMax(rivalMax),
    .contend(contend), .vecValid(vecValid), .vecOut(vecOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 vecValid in reset", vecValid, 0);
    chk("R9 vecOut in reset", vecOut, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4: full sweep of pending x level x mask
    for (int p = 0; p < 2; p++) begin
      for (int l = 0; l < 8; l++) begin
        for (int m = 0; m < 8; m++) begin
          irqPending = p[0];
          irqLevel = l[2:0];
          cpuMask = m[2:0];
          #1;
          if (p == 0) chk("R4 contend without pending", contend, 0);
          else if (l == 0) chk("R1 contend at level 0", contend, 0);
          else if (l == 7) chk("R3 contend at level 7", contend, 1);
          else chk("R2 contend vs mask", contend, (l > m) ? 1 : 0);
        end
      end
    end

    // R5 R6 R7: every local number against every rival number
    irqPending = 1'b1;
    irqLevel = 3'd5;
    cpuMask = 3'd2;
    for (int a = 0; a < 16; a++) begin
      for (int r = 0; r < 16; r++) begin
        @(negedge clk);
        arbTop = a[3];
        arbLow = a[2:0];
        rivalMax = r[3:0];
        vecBase = r[1:0];
        subNum = 6'((a * 5 + r * 3) % 64);
        ackStrobe = 1'b1;
        @(negedge clk);
        chk("R5 R6 win vs rival", vecValid, (a > r) ? 1 : 0);
        chk("R7 R8 vector value", vecOut,
            (a > r) ? (r % 4) * 64 + (a * 5 + r * 3) % 64 : 0);
        ackStrobe = 1'b0;
        @(negedge clk);
        chk("R8 pulse ends", vecValid, 0);
      end
    end

    // R6: contend low means no win even with the largest number
    irqLevel = 3'd0;
    arbTop = 1'b1;
    arbLow = 3'd7;
    rivalMax = 4'd0;
    ackStrobe = 1'b1;
    @(negedge clk);
    chk("R6 no win without contend", vecValid, 0);
    ackStrobe = 1'b0;
    @(negedge clk);

    // R7: submodule 12 gives low bits 001100; R8: held strobe gives one pulse
    irqLevel = 3'd7;
    cpuMask = 3'd7;
    vecBase = 2'b10;
    subNum = 6'd12;
    ackStrobe = 1'b1;
    @(negedge clk);
    chk("R7 submodule 12 low bits", vecOut[5:0], 12);
    chk("R7 base bits", vecOut[7:6], 2);
    chk("R6 level 7 win at mask 7", vecValid, 1);
    @(negedge clk);
    chk("R8 held strobe second cycle", vecValid, 0);
    chk("R8 vecOut cleared", vecOut, 0);
    @(negedge clk);
    chk("R8 held strobe third cycle", vecValid, 0);
    ackStrobe = 1'b0;
    @(negedge clk);

    // R9: reset mid-pulse clears outputs
    ackStrobe = 1'b1;
    rstN = 1'b0;
    @(negedge clk);
    chk("R9 vecValid under reset", vecValid, 0);
    chk("R9 vecOut under reset", vecOut, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule